// File: doc/BRIEF.md
# Dual-Channel Input Capture Unit

This block timestamps external events. It has a 16-bit free-running count that advances once every 2, 4 or 8 system clocks. Two capture channels each watch one external pin. When the chosen edge arrives, a channel copies the count into its own 16-bit register and raises its flag in a shared status byte. If the flags are enabled and the processor has not masked interrupts, a single request line goes high. Software reads the result one byte at a time over a small byte bus.

Two features keep reads coherent and flags reliable. Reading a channel's high byte freezes that channel until its low byte is read. A flag clears only after software reads the status byte and then touches that channel's low byte. A low-power input defers captures: the first qualifying edge seen while it is high is held back silently and is delivered when the input drops. If a reset arrives before that, the held capture is discarded.

Top module: `dual_capture_unit`

## Requirements
- R1: Byte addresses: 0 is the status byte, where bit i is the flag of channel i. Address 1 returns channel 0 bits 15:8 and address 2 returns channel 0 bits 7:0. Addresses 3 and 4 return the same two bytes for channel 1. Any other address reads 0.
- R2: After reset the count is 0. It then increments by one every 2, 4 or 8 clocks for div_sel values 0, 1 and 2. div_sel 3 also divides by 8.
- R3: With edge_rise[i]=1 a low-to-high pin change captures, and with edge_rise[i]=0 a high-to-low change captures. A change in the other direction has no effect.
- R4: irq is high exactly when irq_en is 1, int_mask is 0 and at least one flag is set. A flag set while the request is gated stays pending and raises irq once the gating is lifted.
- R5: A flag clears only on a read (bus_rd) or write (bus_wr) of that channel's low-byte address after a status read that saw the flag set. An LSB access without that status read leaves the flag set.
- R6: The captured value equals count_val plus one, where count_val is taken two clocks after the pin change, in the cycle the synchronised edge is detected.
- R7: A qualifying edge overwrites the capture register even when the flag is already set, so the newest capture is always read back.
- R8: Reading a channel's high byte blocks captures on that channel until its low byte is read. Reading only the low byte blocks nothing.
- R9: Changing edge_rise[i] never causes a capture, whatever the pin level.
- R10: While halt is 1, a qualifying edge sets no flag and does not raise irq. The value of the first such edge is delivered, with its flag, when halt returns to 0.
- R11: A reset discards a capture held during halt and does not alter the capture registers. Releasing reset creates no capture, whatever the pin levels are.
- R12: A capture that lands between the status read and the LSB access keeps the flag set. A fresh status read is then needed before an LSB access can clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Low-power state; captures are deferred while high |
| int_mask | input | 1 | Processor global interrupt mask, 1 = masked |
| irq_en | input | 1 | Shared capture interrupt enable |
| div_sel | input | 2 | Count clock divider select |
| edge_rise | input | 2 | Per-channel active edge, 1 = rising |
| cap_pin | input | 2 | Asynchronous capture pins |
| bus_addr | input | 3 | Byte address |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rdata | output | 8 | Read data for the addressed byte |
| count_val | output | 16 | Current free-running count |
| irq | output | 1 | Shared capture interrupt request |

## Verification
The bench targets the order-sensitive corners:
- A capture that lands between the status read and the low-byte access. A design that clears anyway loses an event.
- A high-byte read followed by an edge. A design without the freeze returns a high and a low byte from two different captures.
- Edge-select changes on an idle pin, and reset released with a pin at its active level. Weak edge detection shows up there as phantom flags.
- Several edges during halt, followed by a reset during halt. A flawed deferral keeps the last edge, flags while halted, or revives a value that the reset should have dropped.

// File: rtl/cap_pkg.sv
package cap_pkg;

   localparam int unsigned STATUS_ADDR = 0;

   function automatic int unsigned hi_addr(input int unsigned ch);
      return 1 + 2 * ch;
   endfunction

   function automatic int unsigned lo_addr(input int unsigned ch);
      return 2 + 2 * ch;
   endfunction

   // terminal value of the prescale counter for a divider select
   function automatic logic [2:0] div_limit(input logic [1:0] sel);
      case (sel)
         2'd0:    return 3'd1;
         2'd1:    return 3'd3;
         default: return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/cap_timebase.sv
module cap_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       div_sel,
   output logic [CNT_W-1:0] count
);
   import cap_pkg::*;

   logic [2:0] pre;
   logic [2:0] lim;

   assign lim = div_limit(div_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre   <= '0;
         count <= '0;
      end else if (pre >= lim) begin
         pre   <= '0;
         count <= count + 1'b1;
      end else begin
         pre   <= pre + 1'b1;
      end
   end

   // R2: count never jumps by more than one
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (count == $past(count)) || (count == $past(count) + 1'b1));

endmodule

// File: rtl/cap_sync.sv
module cap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cap_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];

endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  logic             rise_sel,
   input  logic             halt,
   input  logic             wake,
   input  logic [CNT_W-1:0] count,
   input  logic             msb_rd,
   input  logic             lsb_rd,
   input  logic             lsb_acc,
   input  logic             stat_rd,
   output logic [CNT_W-1:0] cap_val,
   output logic             flag
);
   logic                  pin_s;
   logic                  lvl, prev_lvl, rise_q, sel_chg, ready;
   logic                  hit, take, live_cap, arm, deliver;
   logic                  pend, locked, armed;
   logic [SYNC_STAGES:0]  warm;
   logic [CNT_W-1:0]      stamp, hold_val;

   cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin),
      .q     (pin_s)
   );

   // level normalised so that 1 means "active side of the selected edge"
   assign lvl      = rise_sel ? pin_s : ~pin_s;
   assign sel_chg  = rise_q ^ rise_sel;
   assign ready    = warm[SYNC_STAGES];
   assign hit      = lvl & ~prev_lvl & ~sel_chg & ready;
   assign take     = hit & ~locked;
   assign live_cap = take & ~halt;
   assign arm      = take & halt & ~pend;
   assign deliver  = wake & pend;
   assign stamp    = count + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm     <= '0;
         rise_q   <= 1'b0;
         prev_lvl <= 1'b0;
         pend     <= 1'b0;
         locked   <= 1'b0;
         flag     <= 1'b0;
         armed    <= 1'b0;
      end else begin
         warm     <= {warm[SYNC_STAGES-1:0], 1'b1};
         rise_q   <= rise_sel;
         prev_lvl <= lvl;
         if (arm)          pend <= 1'b1;
         else if (deliver) pend <= 1'b0;
         if (msb_rd)       locked <= 1'b1;
         else if (lsb_rd)  locked <= 1'b0;
         if (live_cap || deliver) begin
            flag  <= 1'b1;
            armed <= 1'b0;
         end else if (lsb_acc) begin
            if (armed) flag <= 1'b0;
            armed <= 1'b0;
         end else if (stat_rd && flag) begin
            armed <= 1'b1;
         end
      end
   end

   // capture data is deliberately not reset
   always_ff @(posedge clk) begin
      if (live_cap)     cap_val <= stamp;
      else if (deliver) cap_val <= hold_val;
      if (arm)          hold_val <= stamp;
   end

   // R8: a frozen channel keeps its value
   a_r8_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !deliver) |=> $stable(cap_val));

   // R5: a flag only falls on a qualified low-byte access
   a_r5_flag_clear_seq: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(lsb_acc && armed));

   // R10: halted cycles never raise the flag
   a_r10_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !$rose(flag));

   // R9: an edge-select change alone never flags
   a_r9_sel_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_chg && !deliver) |=> !$rose(flag));

endmodule

// File: rtl/dual_capture_unit.sv
module dual_capture_unit #(
   parameter int NCH         = 2,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic             int_mask,
   input  logic             irq_en,
   input  logic [1:0]       div_sel,
   input  logic [NCH-1:0]   edge_rise,
   input  logic [NCH-1:0]   cap_pin,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_rd,
   input  logic             bus_wr,
   output logic [7:0]       bus_rdata,
   output logic [CNT_W-1:0] count_val,
   output logic             irq
);
   import cap_pkg::*;

   localparam int NADDR = 2 * NCH + 1;

   generate
      if (CNT_W != 16) begin : g_bad_width
         $error("capture width must be two bytes");
      end
      if (NCH < 1 || NCH > 8) begin : g_bad_nch
         $error("channel count must fit the status byte");
      end
      if ((1 << AW) < NADDR) begin : g_bad_aw
         $error("address width too small for the register set");
      end
   endgenerate

   logic               halt_q, wake, stat_rd;
   logic [NCH-1:0]     flags, msb_rd, lsb_rd, lsb_acc;
   logic [CNT_W-1:0]   cap_arr [NCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) halt_q <= 1'b0;
      else        halt_q <= halt;
   end

   assign wake    = halt_q & ~halt;
   assign stat_rd = bus_rd && (bus_addr == AW'(STATUS_ADDR));

   cap_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (div_sel),
      .count   (count_val)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         assign msb_rd[c]  = bus_rd && (bus_addr == AW'(hi_addr(c)));
         assign lsb_rd[c]  = bus_rd && (bus_addr == AW'(lo_addr(c)));
         assign lsb_acc[c] = (bus_rd || bus_wr) && (bus_addr == AW'(lo_addr(c)));

         cap_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (cap_pin[c]),
            .rise_sel (edge_rise[c]),
            .halt     (halt),
            .wake     (wake),
            .count    (count_val),
            .msb_rd   (msb_rd[c]),
            .lsb_rd   (lsb_rd[c]),
            .lsb_acc  (lsb_acc[c]),
            .stat_rd  (stat_rd),
            .cap_val  (cap_arr[c]),
            .flag     (flags[c])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(STATUS_ADDR)) bus_rdata[NCH-1:0] = flags;
      for (int c = 0; c < NCH; c++) begin
         if (bus_addr == AW'(hi_addr(c))) bus_rdata = cap_arr[c][CNT_W-1 -: 8];
         if (bus_addr == AW'(lo_addr(c))) bus_rdata = cap_arr[c][7:0];
      end
   end

   assign irq = irq_en & ~int_mask & (|flags);

   // R4: request only while enabled and unmasked
   a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && !int_mask));

endmodule

// File: tb/tb_dual_capture_unit.sv
module tb_dual_capture_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n, halt, int_mask, irq_en, bus_rd, bus_wr;
   logic [1:0]  div_sel, edge_rise, cap_pin;
   logic [2:0]  bus_addr;
   logic [7:0]  bus_rdata;
   logic [15:0] count_val;
   logic        irq;

   typedef struct {
      int    addr;
      int    exp;
      string req;
   } rd_item_t;

   rd_item_t sb[$];
   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_capture_unit dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt      (halt),
      .int_mask  (int_mask),
      .irq_en    (irq_en),
      .div_sel   (div_sel),
      .edge_rise (edge_rise),
      .cap_pin   (cap_pin),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_rdata (bus_rdata),
      .count_val (count_val),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // monitor: pops expected read data and compares
   always @(negedge clk) begin
      #1;
      if (bus_rd) begin
         if (sb.size() == 0) begin
            check("R1 unexpected read", 32'd1, 32'd0);
         end else begin
            rd_item_t it;
            it = sb.pop_front();
            check(it.req, {24'd0, bus_rdata}, it.exp);
         end
      end
   end

   task automatic bus_read(input int addr, input int exp, input string req);
      @(negedge clk);
      bus_addr = addr[2:0];
      bus_rd   = 1'b1;
      sb.push_back('{addr, exp, req});
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input int addr);
      @(negedge clk);
      bus_addr = addr[2:0];
      bus_wr   = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // drive a pin and return count+1 taken in the detection cycle
   task automatic pin_edge(input int ch, input logic val, output logic [15:0] exp);
      @(negedge clk);
      cap_pin[ch] = val;
      @(negedge clk);
      @(negedge clk);
      exp = count_val + 16'd1;
      @(negedge clk);
   endtask

   task automatic read_cap(input int ch, input logic [15:0] v, input string req);
      bus_read(1 + 2 * ch, int'(v[15:8]), req);
      bus_read(2 + 2 * ch, int'(v[7:0]), req);
   endtask

   task automatic chk_div(input logic [1:0] sel, input int div);
      logic [15:0] v;
      @(negedge clk);
      div_sel = sel;
      v = count_val;
      for (int k = 0; k < 40 && count_val == v; k++) @(negedge clk);
      v = count_val;
      repeat (div * 4) @(negedge clk);
      check("R2 divider", {16'd0, count_val}, {16'd0, v + 16'd4});
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check("watchdog expired", 32'd1, 32'd0);
      summary();
   end

   initial begin
      logic [15:0] e, e1, ea, eb, ec, ed, ef, h1, h3, x;
      rst_n = 1'b0; halt = 1'b0; int_mask = 1'b1; irq_en = 1'b0;
      div_sel = 2'd0; edge_rise = 2'b01; cap_pin = 2'b10;
      bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
      wait_cyc(5);
      #1;
      check("R2 count at reset", {16'd0, count_val}, 32'd0);
      check("R4 irq at reset", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      bus_read(0, 0, "R1 status after reset");
      bus_read(5, 0, "R1 unused address");

      chk_div(2'd0, 2);
      chk_div(2'd1, 4);
      chk_div(2'd2, 8);
      chk_div(2'd3, 8);
      div_sel = 2'd0;

      // rising capture on channel 0, interrupt gating
      pin_edge(0, 1'b1, e);
      bus_read(0, 1, "R1 status ch0");
      irq_en = 1'b1; int_mask = 1'b0; #1;
      check("R4 irq raised", {31'd0, irq}, 32'd1);
      int_mask = 1'b1; #1;
      check("R4 irq masked", {31'd0, irq}, 32'd0);
      int_mask = 1'b0;
      read_cap(0, e, "R6 capture value ch0");
      bus_read(0, 0, "R5 cleared by sequence");
      #1 check("R4 irq after clear", {31'd0, irq}, 32'd0);

      // wrong edge
      pin_edge(0, 1'b0, x);
      bus_read(0, 0, "R3 falling edge ignored on rising channel");

      // falling capture on channel 1
      pin_edge(1, 1'b0, e1);
      bus_read(0, 2, "R3 falling capture ch1");
      read_cap(1, e1, "R6 capture value ch1");
      bus_read(0, 0, "R5 ch1 cleared");

      // LSB access without status read
      pin_edge(0, 1'b1, e);
      bus_read(2, int'(e[7:0]), "R5 lsb read before status");
      bus_read(0, 1, "R5 flag survives bare lsb read");
      bus_write(2);
      bus_read(0, 0, "R5 lsb write clears");

      // overwrite
      pin_edge(0, 1'b0, x);
      pin_edge(0, 1'b1, ea);
      pin_edge(0, 1'b0, x);
      pin_edge(0, 1'b1, eb);
      check("R7 captures differ", {31'd0, ea != eb}, 32'd1);
      bus_read(0, 1, "R7 status");
      read_cap(0, eb, "R7 newest capture kept");

      // high-byte lock
      pin_edge(0, 1'b0, x);
      bus_read(1, int'(eb[15:8]), "R8 msb read");
      pin_edge(0, 1'b1, x);
      bus_read(0, 0, "R8 capture blocked while locked");
      bus_read(2, int'(eb[7:0]), "R8 old lsb kept");
      pin_edge(0, 1'b0, x);
      pin_edge(0, 1'b1, ec);
      bus_read(0, 1, "R8 capture after unlock");
      bus_read(2, int'(ec[7:0]), "R8 lsb only");
      pin_edge(0, 1'b0, x);
      pin_edge(0, 1'b1, ed);
      bus_read(0, 1, "R8 lsb read did not lock");
      read_cap(0, ed, "R8 value after lsb-only read");
      bus_read(0, 0, "R8 cleared");

      // edge-select change
      pin_edge(0, 1'b0, x);
      @(negedge clk); edge_rise[0] = 1'b0;
      wait_cyc(5);
      bus_read(0, 0, "R9 select to falling no capture");
      @(negedge clk); edge_rise[0] = 1'b1;
      wait_cyc(5);
      bus_read(0, 0, "R9 select to rising no capture");

      // capture between status read and LSB access
      pin_edge(0, 1'b1, e);
      bus_read(0, 1, "R12 status arms");
      pin_edge(0, 1'b0, x);
      pin_edge(0, 1'b1, ef);
      bus_read(2, int'(ef[7:0]), "R12 lsb of newer capture");
      bus_read(0, 1, "R12 flag kept");
      irq_en = 1'b0; #1;
      check("R4 irq disabled", {31'd0, irq}, 32'd0);
      irq_en = 1'b1; #1;
      check("R4 pending irq appears", {31'd0, irq}, 32'd1);
      bus_read(2, int'(ef[7:0]), "R12 second lsb");
      bus_read(0, 0, "R12 cleared after fresh status read");

      // halt arming
      pin_edge(0, 1'b0, x);
      @(negedge clk); halt = 1'b1;
      pin_edge(0, 1'b1, h1);
      pin_edge(0, 1'b0, x);
      pin_edge(0, 1'b1, x);
      #1 check("R10 no irq during halt", {31'd0, irq}, 32'd0);
      bus_read(0, 0, "R10 no flag during halt");
      @(negedge clk); halt = 1'b0;
      @(negedge clk); #1;
      check("R10 irq after wake", {31'd0, irq}, 32'd1);
      bus_read(0, 1, "R10 flag after wake");
      read_cap(0, h1, "R10 first halted edge kept");
      bus_read(0, 0, "R10 cleared");

      // reset during halt
      pin_edge(0, 1'b0, x);
      @(negedge clk); halt = 1'b1;
      pin_edge(0, 1'b1, h3);
      pin_edge(0, 1'b0, x);
      @(negedge clk); rst_n = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1; halt = 1'b0;
      wait_cyc(6);
      check("R11 armed value differs", {31'd0, h3 != h1}, 32'd1);
      bus_read(0, 0, "R11 armed capture discarded");
      read_cap(0, h1, "R11 capture register survives reset");

      wait_cyc(4);
      summary();
   end

endmodule